// File: doc/BRIEF.md
# Tagged Multi-Client Memory Request Arbiter

This block sits between seven client request queues and a single memory request queue that feeds a memory controller. Four clients read memory: display, stream-buffer read, forward reference and backward reference. Three write it: stream-buffer write, reconstructed frame and on-screen display. The block chooses one client by fixed priority and pops one entry from that client's queue. It then writes a request word into the memory request queue. The word holds a 2-bit command, a 22-bit word address and 64 bits of data. For every read it also pushes a 3-bit requester tag into a tag queue, so that returning data can be routed back to the right client.

Back-pressure comes in two kinds. Each read client has its own response-FIFO almost-full bit, and that bit blocks only that client. The almost-full flags of the request queue and the tag queue block every client. After reset the block first writes zero to every word of frame memory and serves no client until that sweep has finished. The length of the sweep is a parameter, so a small memory can be used for test.

Top module: `memreq_arbiter`

## Requirements
- R1: While reset is held, `mreq_wr`, `tag_wr` and every bit of `cli_pop` are 0.
- R2: After reset the block writes `CLEAR_WORDS` requests with command 11, addresses 0, 1, 2 and so on upward in order, data zero and no tag. It asserts no `cli_pop` before the last of these writes.
- R3: During the sweep, a write appears on `mreq_wr` only when `mreq_afull` was low in the cycle before. While `mreq_afull` is high the sweep pauses and skips no address.
- R4: `cli_pop` has at most one bit set and is never high in two consecutive cycles. Suppose client i is popped in cycle t and its `cli_valid` bit is high in cycle t+1. Then in cycle t+2 `mreq_wr` is 1 and carries that client's `cli_addr` slot. If the valid bit is low in cycle t+1, no request follows.
- R5: A read client produces command 10 with data zero, even when its `cli_data` slot is nonzero. A write client produces command 11 with its `cli_data` slot. Codes 00 and 01 are never issued.
- R6: `tag_wr` is high in exactly the cycles in which a read request is written. `tag_id` is 1 for forward, 2 for backward, 3 for display and 4 for stream-buffer read.
- R7: A read client is never popped while its response almost-full bit is high. Bit 0 of `rsp_afull` belongs to forward, bit 1 to backward, bit 2 to display and bit 3 to stream-buffer read.
- R8: No client is popped while `mreq_afull` or `tag_afull` is high.
- R9: Client slot i covers bit i of every per-client vector and bits [i*22 +: 22] of `cli_addr` and [i*64 +: 64] of `cli_data`. The slots are 0 display read, 1 stream-buffer read, 2 stream-buffer write, 3 forward read, 4 backward read, 5 reconstruction write and 6 on-screen-display write. Among the eligible clients, the lowest slot wins.
- R10: An eligible client whose `cli_aempty` bit is high wins only when no eligible client with `cli_aempty` low exists.
- R11: A client whose `cli_empty` bit is high is never popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cli_empty | input | 7 | Per-client queue empty |
| cli_aempty | input | 7 | Per-client queue almost empty |
| cli_pop | output | 7 | Per-client one-cycle read enable |
| cli_valid | input | 7 | Per-client entry valid, the cycle after a pop |
| cli_addr | input | 154 | Per-client word address, 22 bits per slot |
| cli_data | input | 448 | Per-client write data, 64 bits per slot |
| rsp_afull | input | 4 | Response FIFO almost full: forward, backward, display, stream-buffer read |
| mreq_afull | input | 1 | Memory request queue almost full |
| tag_afull | input | 1 | Tag queue almost full |
| mreq_wr | output | 1 | Write strobe into the memory request queue |
| mreq_cmd | output | 2 | Command: 10 read, 11 write |
| mreq_addr | output | 22 | Request word address |
| mreq_data | output | 64 | Request data |
| tag_wr | output | 1 | Write strobe into the tag queue |
| tag_id | output | 3 | Requester tag |

## Verification
The sweep counter or its done flag could be wrong. That shows up at once as a skipped or repeated address, a write made while the request queue was almost full, or a pop that comes before the last clear write. A grant register that holds the wrong client shows up two cycles after the pop, as a request with the wrong address, command, data or tag. Errors in eligibility or priority show up in the pop vector in the same cycle the inputs are applied. The bench therefore tries every empty mask with every response-throttle mask and several almost-empty masks, and compares each result against a winner it computes itself.

// File: rtl/memreq_pkg.sv
`timescale 1ns/1ps
// Shared types and per-slot constants for the memory request arbiter.
// Assumes seven client slots in fixed priority order, lowest slot first.
package memreq_pkg;
    localparam int NCLI  = 7;
    localparam int TAG_W = 3;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_REFRESH = 2'b01,
        CMD_READ    = 2'b10,
        CMD_WRITE   = 2'b11
    } mem_cmd_e;

    typedef enum logic {PH_PICK, PH_FETCH} phase_e;

    // Slot is a read client (display, stream read, forward, backward).
    function automatic logic cli_is_read(input int slot);
        return (slot == 0) || (slot == 1) || (slot == 3) || (slot == 4);
    endfunction

    // Response-FIFO almost-full bit that throttles a read slot.
    function automatic int cli_rsp_bit(input int slot);
        case (slot)
            0: return 2;
            1: return 3;
            3: return 0;
            4: return 1;
            default: return 0;
        endcase
    endfunction

    // Tag naming the requester of a read slot.
    function automatic logic [TAG_W-1:0] cli_tag(input int slot);
        case (slot)
            0: return 3'd3;
            1: return 3'd4;
            3: return 3'd1;
            4: return 3'd2;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/memreq_clear_sweep.sv
`timescale 1ns/1ps
// Post-reset zero sweep: walks addresses 0..WORDS-1 once, one per cycle,
// pausing while the request queue is almost full. Assumes WORDS >= 1.
module memreq_clear_sweep #(
    parameter int ADDR_W = 22,
    parameter int WORDS  = 32'h78000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    output logic              issue,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

    // Issue a zero write whenever the sweep is running and not held.
    assign issue = !done && !hold;

    // Advance the address and flag completion after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            done <= 1'b0;
        end else if (issue) begin
            if (addr == LAST) done <= 1'b1;
            else              addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/memreq_prio_pick.sv
`timescale 1ns/1ps
// Two-pass fixed-priority picker: the lowest eligible slot that is not
// almost empty wins; if none, the lowest eligible slot. Output is one-hot or zero.
module memreq_prio_pick #(
    parameter int N = 7
) (
    input  logic [N-1:0] elig,
    input  logic [N-1:0] aempty,
    output logic [N-1:0] grant
);
    logic [N-1:0] pref;

    // Isolate the lowest set bit of the preferred set, else of the eligible set.
    always_comb begin
        pref = elig & ~aempty;
        if (|pref) grant = pref & (~pref + 1'b1);
        else       grant = elig & (~elig + 1'b1);
    end
endmodule

// File: rtl/memreq_arbiter.sv
`timescale 1ns/1ps
// Memory request arbiter: after a zero sweep of memory, pops one client
// queue at a time by priority, registers its entry as a memory request and
// tags reads with their requester. Assumes client queues return their entry
// with a valid flag exactly one cycle after the pop.
module memreq_arbiter
    import memreq_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 64,
    parameter int CLEAR_WORDS = 32'h78000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCLI-1:0]        cli_empty,
    input  logic [NCLI-1:0]        cli_aempty,
    output logic [NCLI-1:0]        cli_pop,
    input  logic [NCLI-1:0]        cli_valid,
    input  logic [NCLI*ADDR_W-1:0] cli_addr,
    input  logic [NCLI*DATA_W-1:0] cli_data,
    input  logic [3:0]             rsp_afull,
    input  logic                   mreq_afull,
    input  logic                   tag_afull,
    output logic                   mreq_wr,
    output logic [1:0]             mreq_cmd,
    output logic [ADDR_W-1:0]      mreq_addr,
    output logic [DATA_W-1:0]      mreq_data,
    output logic                   tag_wr,
    output logic [TAG_W-1:0]       tag_id
);
    logic              sw_issue, sw_done;
    logic [ADDR_W-1:0] sw_addr;
    logic              room;
    logic [NCLI-1:0]   elig, grant, grant_q, is_rd_v;
    logic [TAG_W-1:0]  tag_v [NCLI];
    phase_e            phase;
    logic              hit, sel_rd;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    logic [TAG_W-1:0]  sel_tag;

    memreq_clear_sweep #(.ADDR_W(ADDR_W), .WORDS(CLEAR_WORDS)) u_sweep (
        .clk(clk), .rst_n(rst_n), .hold(mreq_afull),
        .issue(sw_issue), .addr(sw_addr), .done(sw_done)
    );

    // Both shared queues must have room before any client is considered.
    assign room = !mreq_afull && !tag_afull;

    // Per-slot eligibility and constants; reads also need response room.
    for (genvar i = 0; i < NCLI; i++) begin : g_slot
        assign tag_v[i] = cli_tag(i);
        if (cli_is_read(i)) begin : g_rd
            assign is_rd_v[i] = 1'b1;
            assign elig[i] = !cli_empty[i] && !rsp_afull[cli_rsp_bit(i)] && room;
        end else begin : g_wr
            assign is_rd_v[i] = 1'b0;
            assign elig[i] = !cli_empty[i] && room;
        end
    end

    memreq_prio_pick #(.N(NCLI)) u_pick (
        .elig(elig), .aempty(cli_aempty), .grant(grant)
    );

    // Pop only in the pick phase, once the sweep has finished.
    assign cli_pop = (phase == PH_PICK && sw_done) ? grant : '0;

    // Mux the granted slot's entry, command kind and tag.
    always_comb begin
        sel_addr = '0;
        sel_data = '0;
        sel_rd   = 1'b0;
        sel_tag  = '0;
        for (int i = 0; i < NCLI; i++) begin
            if (grant_q[i]) begin
                sel_addr = sel_addr | cli_addr[i*ADDR_W +: ADDR_W];
                sel_data = sel_data | cli_data[i*DATA_W +: DATA_W];
                sel_rd   = sel_rd | is_rd_v[i];
                sel_tag  = sel_tag | tag_v[i];
            end
        end
        hit = |(grant_q & cli_valid);
    end

    // Alternate pick and fetch phases, remembering the granted slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_PICK;
            grant_q <= '0;
        end else if (phase == PH_PICK) begin
            if (sw_done && |grant) begin
                phase   <= PH_FETCH;
                grant_q <= grant;
            end
        end else begin
            phase <= PH_PICK;
        end
    end

    // Register the outgoing request and tag, sweep writes first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_wr   <= 1'b0;
            mreq_cmd  <= CMD_NOP;
            mreq_addr <= '0;
            mreq_data <= '0;
            tag_wr    <= 1'b0;
            tag_id    <= '0;
        end else begin
            mreq_wr <= 1'b0;
            tag_wr  <= 1'b0;
            if (sw_issue) begin
                mreq_wr   <= 1'b1;
                mreq_cmd  <= CMD_WRITE;
                mreq_addr <= sw_addr;
                mreq_data <= '0;
                tag_id    <= '0;
            end else if (phase == PH_FETCH && hit) begin
                mreq_wr   <= 1'b1;
                mreq_cmd  <= sel_rd ? CMD_READ : CMD_WRITE;
                mreq_addr <= sel_addr;
                mreq_data <= sel_rd ? '0 : sel_data;
                tag_wr    <= sel_rd;
                tag_id    <= sel_tag;
            end
        end
    end
endmodule

// File: rtl/memreq_arbiter_checker.sv
`timescale 1ns/1ps
// Protocol checker for memreq_arbiter; attached by bind below.
module memreq_arbiter_checker #(
    parameter int NCLI = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCLI-1:0] cli_pop,
    input logic            mreq_wr,
    input logic [1:0]      mreq_cmd,
    input logic [63:0]     mreq_data,
    input logic            tag_wr,
    input logic            mreq_afull,
    input logic            sw_done
);
    // R4: at most one client popped, never two cycles running.
    a_r4_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cli_pop));
    a_r4_pop_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (|cli_pop) |=> (cli_pop == '0));
    // R2: no client served while the sweep is still running.
    a_r2_no_pop_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_done |-> (cli_pop == '0));
    // R3: sweep writes only follow a cycle with room in the request queue.
    a_r3_sweep_respects_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_wr && !$past(sw_done)) |-> !$past(mreq_afull));
    // R5: only read or write codes; reads carry zero data.
    a_r5_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_wr |-> mreq_cmd[1]);
    a_r5_read_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_wr && mreq_cmd == 2'b10) |-> (mreq_data == '0));
    // R6: a tag is pushed exactly with each read request.
    a_r6_tag_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        tag_wr == (mreq_wr && mreq_cmd == 2'b10));
endmodule

bind memreq_arbiter memreq_arbiter_checker #(.NCLI(memreq_pkg::NCLI)) u_chk (
    .clk(clk), .rst_n(rst_n), .cli_pop(cli_pop), .mreq_wr(mreq_wr),
    .mreq_cmd(mreq_cmd), .mreq_data(mreq_data), .tag_wr(tag_wr),
    .mreq_afull(mreq_afull), .sw_done(sw_done)
);

// File: tb/memreq_arbiter_test.sv
`timescale 1ns/1ps
// Bench: zero sweep with intermittent back-pressure, then every empty mask
// against every response-throttle mask and several almost-empty masks.
module memreq_arbiter_test;
    localparam int N  = 7;
    localparam int AW = 22;
    localparam int DW = 64;
    localparam int CW = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cli_empty = '0, cli_aempty = '0, cli_valid = '0;
    logic [N-1:0]    cli_pop;
    logic [N*AW-1:0] cli_addr = '0;
    logic [N*DW-1:0] cli_data = '0;
    logic [3:0]      rsp_afull = '0;
    logic            mreq_afull = 1'b0, tag_afull = 1'b0;
    logic            mreq_wr, tag_wr;
    logic [1:0]      mreq_cmd;
    logic [AW-1:0]   mreq_addr;
    logic [DW-1:0]   mreq_data;
    logic [2:0]      tag_id;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    memreq_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CLEAR_WORDS(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cli_empty(cli_empty), .cli_aempty(cli_aempty),
        .cli_pop(cli_pop), .cli_valid(cli_valid), .cli_addr(cli_addr),
        .cli_data(cli_data), .rsp_afull(rsp_afull), .mreq_afull(mreq_afull),
        .tag_afull(tag_afull), .mreq_wr(mreq_wr), .mreq_cmd(mreq_cmd),
        .mreq_addr(mreq_addr), .mreq_data(mreq_data), .tag_wr(tag_wr), .tag_id(tag_id)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_rd(input int s);
        return s == 0 || s == 1 || s == 3 || s == 4;
    endfunction

    function automatic int rbit(input int s);
        return (s == 0) ? 2 : (s == 1) ? 3 : (s == 3) ? 0 : 1;
    endfunction

    function automatic logic [2:0] tag_of(input int s);
        return (s == 0) ? 3'd3 : (s == 1) ? 3'd4 : (s == 3) ? 3'd1 : (s == 4) ? 3'd2 : 3'd0;
    endfunction

    // Reference winner from R7..R11.
    function automatic logic [N-1:0] winner(input logic [N-1:0] e, input logic [N-1:0] a,
                                            input logic [3:0] r, input bit maf, input bit taf);
        logic [N-1:0] el = '0;
        for (int s = 0; s < N; s++)
            el[s] = !e[s] && !maf && !taf && !(is_rd(s) && r[rbit(s)]);
        for (int s = 0; s < N; s++) if (el[s] && !a[s]) return N'(1) << s;
        for (int s = 0; s < N; s++) if (el[s]) return N'(1) << s;
        return '0;
    endfunction

    task automatic run_case(input int n, input logic [N-1:0] e, input logic [N-1:0] a,
                            input logic [3:0] r, input bit maf, input bit taf, input bit give);
        logic [N-1:0] exp_g, got;
        int g;
        @(negedge clk);
        cli_empty = e; cli_aempty = a; rsp_afull = r; mreq_afull = maf; tag_afull = taf;
        #1;
        exp_g = winner(e, a, r, maf, taf);
        got = cli_pop;
        check(got == exp_g, "R7 R8 R9 R10 R11 grant", 64'(got), 64'(exp_g));
        @(negedge clk);
        cli_empty = '1; mreq_afull = 1'b0; tag_afull = 1'b0; rsp_afull = '0;
        cli_valid = give ? got : '0;
        for (int s = 0; s < N; s++) begin
            cli_addr[s*AW +: AW] = AW'(n * 13 + s * 3 + 5);
            cli_data[s*DW +: DW] = {32'(n), 32'(s)} ^ 64'h5A5A_0F0F_3C3C_9696;
        end
        #1;
        check(cli_pop == '0, "R4 no pop in fetch", 64'(cli_pop), 64'd0);
        @(negedge clk);
        cli_valid = '0;
        g = -1;
        for (int s = 0; s < N; s++) if (exp_g[s]) g = s;
        if (g >= 0 && give) begin
            check(mreq_wr == 1'b1, "R4 request issued", 64'(mreq_wr), 64'd1);
            check(mreq_addr == AW'(n * 13 + g * 3 + 5), "R4 address",
                  64'(mreq_addr), 64'(n * 13 + g * 3 + 5));
            check(mreq_cmd == (is_rd(g) ? 2'b10 : 2'b11), "R5 command",
                  64'(mreq_cmd), is_rd(g) ? 64'd2 : 64'd3);
            check(mreq_data == (is_rd(g) ? 64'd0 : ({32'(n), 32'(g)} ^ 64'h5A5A_0F0F_3C3C_9696)),
                  "R5 data", mreq_data, 64'd0);
            check(tag_wr == is_rd(g), "R6 tag strobe", 64'(tag_wr), 64'(is_rd(g)));
            if (is_rd(g))
                check(tag_id == tag_of(g), "R6 tag value", 64'(tag_id), 64'(tag_of(g)));
        end else begin
            check(mreq_wr == 1'b0 && tag_wr == 1'b0, "R4 no request", 64'(mreq_wr), 64'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seen, k, n;
        bit prev_af;
        repeat (3) @(negedge clk);
        check(mreq_wr == 1'b0 && tag_wr == 1'b0, "R1 idle in reset", 64'(mreq_wr), 64'd0);
        check(cli_pop == '0, "R1 no pop in reset", 64'(cli_pop), 64'd0);
        rst_n = 1'b1;
        seen = 0; k = 0; prev_af = 1'b0;
        while (seen < CW && k < 500) begin
            @(negedge clk);
            if (mreq_wr) begin
                check(mreq_cmd == 2'b11 && mreq_data == '0 && !tag_wr, "R2 zero write",
                      64'(mreq_cmd), 64'd3);
                check(mreq_addr == AW'(seen), "R2 ascending address", 64'(mreq_addr), 64'(seen));
                check(!prev_af, "R3 write after full", 64'(prev_af), 64'd0);
                seen++;
            end
            if (seen < CW)
                check(cli_pop == '0, "R2 no pop during sweep", 64'(cli_pop), 64'd0);
            prev_af = ((k % 7) >= 5);
            mreq_afull = prev_af;
            if (seen == CW) begin
                cli_empty = '1;
                mreq_afull = 1'b0;
            end
            k++;
        end
        check(seen == CW, "R2 sweep length", 64'(seen), 64'(CW));
        repeat (2) @(negedge clk);
        check(mreq_wr == 1'b0, "R2 sweep stops", 64'(mreq_wr), 64'd0);

        n = 0;
        for (int e = 0; e < 128; e++) begin
            for (int r = 0; r < 16; r++) begin
                for (int ai = 0; ai < 4; ai++) begin
                    logic [N-1:0] am;
                    am = (ai == 0) ? 7'h00 : (ai == 1) ? 7'h55 : (ai == 2) ? 7'h2A : 7'h7F;
                    run_case(n, N'(e), am, 4'(r), 1'b0, 1'b0, 1'b1);
                    n++;
                end
            end
        end
        for (int e = 0; e < 128; e++) begin
            run_case(n, N'(e), '0, '0, 1'b1, 1'b0, 1'b1); n++;
            run_case(n, N'(e), '0, '0, 1'b0, 1'b1, 1'b1); n++;
        end
        for (int e = 0; e < 16; e++) begin
            run_case(n, N'(e * 5), '0, '0, 1'b0, 1'b0, 1'b0); n++;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule